// File: doc/BRIEF.md
# Write Status Polling Generator

This block forms the byte that a host read returns from a flash device. While the device runs an internal program or erase cycle, the array contents are not readable. During that time the read path returns a status byte instead, and the host polls it to find out when the write has finished. Two bits of that byte carry status:

- **Polling bit (bit 7).** During a program it shows the inverse of the bit being written. During an erase it reads low.
- **Toggle bit (bit 6).** It changes value after every finished read, for as long as the device stays busy.

All other bits read as a fixed fill value of zero. When the busy flag drops, the output falls back to plain array data.

The command sequencer reports two things. It pulses `op_start_i` in the cycle in which it accepts a program or erase command. From the next cycle on it holds `busy_i` high for the length of the internal operation. This ordering means status reporting starts only after the final write cycle of the command sequence: the fourth write for a program, the sixth for an erase. Read strobes are active-low and synchronous to `clk`. A read is taken as finished in the cycle in which either strobe rises after both were low. The asynchronous reset is released to the internal flops through a two-stage synchronizer.

Top module: `wr_status_gen`

## Requirements
- R1: While reset is applied, and for the two clock edges after `rst_n` rises, the block holds the following state: toggle 0, operation kind program, latched data 0x00. In this state, with `busy_i` high, `dq_o` reads 0x80.
- R2: While `busy_i` is low, `dq_o` equals `arr_data_i` in the same cycle.
- R3: While `busy_i` is high after a program start (`op_kind_i` = 0), bit 7 of `dq_o` is the inverse of bit 7 of the data latched at the start.
- R4: While `busy_i` is high after an erase start (`op_kind_i` = 1), bit 7 of `dq_o` is 0.
- R5: While `busy_i` is high, bit 6 of `dq_o` shows the toggle state. The toggle state inverts on the clock edge that ends a cycle in which a read finished. A read finishes when `oe_n_i` or `ce_n_i` is high and both were low in the previous cycle.
- R6: The toggle state holds its value while a read is still in progress and while `busy_i` is low.
- R7: When `op_start_i` is high and `busy_i` is low, the next clock edge does three things: it clears the toggle state to 0, it latches `op_kind_i`, and it latches `prog_data_i`. Later changes of `prog_data_i` have no effect.
- R8: When `op_start_i` is high while `busy_i` is high, the pulse is ignored. The latched kind, the latched data and the toggle state are all left unchanged.
- R9: While `busy_i` is high, bits 5 to 0 of `dq_o` are 0.
- R10: In the cycle in which `busy_i` falls, `dq_o` returns to `arr_data_i` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| busy_i | input | 1 | Internal program or erase in progress |
| op_start_i | input | 1 | Command accepted; latch kind and data |
| op_kind_i | input | 1 | 0 = program, 1 = erase |
| prog_data_i | input | 8 | Byte being programmed |
| oe_n_i | input | 1 | Output enable, active low |
| ce_n_i | input | 1 | Chip enable, active low |
| arr_data_i | input | 8 | Data read from the array |
| dq_o | output | 8 | Byte returned on a read |

## Verification
A toggle flop stuck or flipping at the wrong moment shows on bit 6 one cycle after the read that ends. A host would see it as an early "done" or as endless busy. A stale or wrongly latched context shows on bit 7 in the first busy cycle after the start. If a start arriving mid-operation is wrongly accepted, bit 6 clears and bit 7 changes in the very next cycle. A reference model predicts `dq_o` on every clock, so each such fault appears within one cycle of the cause.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;
endpackage

// File: rtl/wsg_rst_sync.sv
module wsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/wsg_read_detect.sv
module wsg_read_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n_i,
  input  logic ce_n_i,
  output logic rd_done_o
);
  logic rd_active;
  logic rd_prev_q;

  assign rd_active = !oe_n_i && !ce_n_i;
  // A read ends when either strobe rises after both were low
  assign rd_done_o = rd_prev_q && !rd_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev_q <= 1'b0;
    else        rd_prev_q <= rd_active;
  end
endmodule

// File: rtl/wsg_op_context.sv
module wsg_op_context
  import wsg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              start_i,
  input  op_kind_e          kind_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              accept_o,
  output op_kind_e          kind_q,
  output logic [DATA_W-1:0] data_q
);
  op_kind_e          kind_d;
  logic [DATA_W-1:0] data_d;

  // A start during a running operation is dropped
  assign accept_o = start_i && !busy_i;

  always_comb begin
    kind_d = kind_q;
    data_d = data_q;
    if (accept_o) begin
      kind_d = kind_i;
      data_d = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_PROGRAM;
      data_q <= '0;
    end else if (accept_o) begin
      kind_q <= kind_d;
      data_q <= data_d;
    end
  end

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && start_i) |=> ($stable(kind_q) && $stable(data_q)));

  a_r7_start_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_i) |=> (data_q == $past(data_i)));
endmodule

// File: rtl/wsg_toggle.sv
module wsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic busy_i,
  input  logic rd_done_i,
  output logic tog_q
);
  logic tog_d;
  logic tog_en;

  assign tog_en = clear_i || (busy_i && rd_done_i);

  always_comb begin
    if (clear_i) tog_d = 1'b0;
    else         tog_d = !tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

  a_r5_flip_on_read_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_done_i && !clear_i) |=> (tog_q != $past(tog_q)));

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !clear_i) |=> $stable(tog_q));

  a_r6_hold_mid_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_done_i && !clear_i) |=> $stable(tog_q));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !tog_q);
endmodule

// File: rtl/wsg_out_mux.sv
module wsg_out_mux
  import wsg_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              POLL_BIT   = DATA_W - 1,
  parameter int              TOGGLE_BIT = DATA_W - 2,
  parameter logic [DATA_W-1:0] BUSY_FILL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  op_kind_e          kind_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] arr_i,
  output logic [DATA_W-1:0] dq_o
);
  logic poll_bit;

  assign poll_bit = (kind_i == OP_ERASE) ? 1'b0 : !data_i[POLL_BIT];

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign dq_o[b] = busy_i ? poll_bit : arr_i[b];
    end else if (b == TOGGLE_BIT) begin : g_tog
      assign dq_o[b] = busy_i ? tog_i : arr_i[b];
    end else begin : g_fill
      assign dq_o[b] = busy_i ? BUSY_FILL[b] : arr_i[b];
    end
  end

  a_r2_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (dq_o == arr_i));

  a_r4_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && kind_i == OP_ERASE) |-> !dq_o[POLL_BIT]);
endmodule

// File: rtl/wr_status_gen.sv
module wr_status_gen
  import wsg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              op_start_i,
  input  logic              op_kind_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              oe_n_i,
  input  logic              ce_n_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] dq_o
);
  localparam int POLL_BIT   = DATA_W - 1;
  localparam int TOGGLE_BIT = DATA_W - 2;

  logic              rst_s;
  logic              rd_done;
  logic              accept;
  logic              tog;
  op_kind_e          kind_q;
  logic [DATA_W-1:0] data_q;

  wsg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_s)
  );

  wsg_read_detect u_rd (
    .clk(clk), .rst_n(rst_s), .oe_n_i(oe_n_i), .ce_n_i(ce_n_i),
    .rd_done_o(rd_done)
  );

  wsg_op_context #(.DATA_W(DATA_W)) u_ctx (
    .clk(clk), .rst_n(rst_s), .busy_i(busy_i), .start_i(op_start_i),
    .kind_i(op_kind_e'(op_kind_i)), .data_i(prog_data_i),
    .accept_o(accept), .kind_q(kind_q), .data_q(data_q)
  );

  wsg_toggle u_tog (
    .clk(clk), .rst_n(rst_s), .clear_i(accept), .busy_i(busy_i),
    .rd_done_i(rd_done), .tog_q(tog)
  );

  wsg_out_mux #(
    .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT),
    .BUSY_FILL('0)
  ) u_mux (
    .clk(clk), .rst_n(rst_s), .busy_i(busy_i), .kind_i(kind_q),
    .data_i(data_q), .tog_i(tog), .arr_i(arr_data_i), .dq_o(dq_o)
  );

  a_r9_fill_zero: assert property (@(posedge clk) disable iff (!rst_s)
    busy_i |-> (dq_o[TOGGLE_BIT-1:0] == '0));

  a_r3_program_poll: assert property (@(posedge clk) disable iff (!rst_s)
    (accept && op_kind_i == 1'b0) ##1 (busy_i && !op_start_i)
      |-> (dq_o[POLL_BIT] == !$past(prog_data_i[POLL_BIT])));
endmodule

// File: tb/wr_status_gen_tb.sv
module wr_status_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       busy, start, kind, oe_n, ce_n;
  logic [7:0] pdata, arr;
  logic [7:0] dq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  bit       m_rs1, m_rs2, m_tog, m_kind, m_rdprev;
  bit [7:0] m_data;

  always #4 clk = !clk;

  wr_status_gen u_dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_start_i(start),
    .op_kind_i(kind), .prog_data_i(pdata), .oe_n_i(oe_n), .ce_n_i(ce_n),
    .arr_data_i(arr), .dq_o(dq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_tog = 0; m_kind = 0; m_data = 0; m_rdprev = 0;
    end else begin
      if (!m_rs2) begin
        m_tog = 0; m_kind = 0; m_data = 0; m_rdprev = 0;
      end else begin
        if (start && !busy) begin
          m_tog = 0; m_kind = kind; m_data = pdata;
        end else if (busy && m_rdprev && !(!oe_n && !ce_n)) begin
          m_tog = !m_tog;
        end
        m_rdprev = !oe_n && !ce_n;
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  function automatic logic [7:0] model_dq();
    if (!busy) return arr;
    return {(m_kind ? 1'b0 : !m_data[7]), m_tog, 6'b0};
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (!done) begin
      checks++;
      if (dq !== model_dq()) begin
        fails++;
        $display("FAIL %s model: dq=%h expected=%h",
                 !m_rs2 ? "R1" : (!busy ? "R2" : (m_kind ? "R4" : "R3")),
                 dq, model_dq());
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] exp);
    checks++;
    if (dq !== exp) begin
      fails++;
      $display("FAIL %s: dq=%h expected=%h", req, dq, exp);
    end
  endtask

  task automatic step(input logic b, input logic s, input logic k,
                      input logic [7:0] pd, input logic o, input logic c,
                      input logic [7:0] a);
    @(negedge clk);
    busy = b; start = s; kind = k; pdata = pd; oe_n = o; ce_n = c; arr = a;
    #2;
  endtask

  initial begin
    #(8 * 5000);
    fails++;
    $display("FAIL watchdog: dq=%h expected=done", dq);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; busy = 1; start = 0; kind = 0; pdata = 8'h00;
    oe_n = 1; ce_n = 1; arr = 8'h3C;
    #1;
    step(1, 0, 0, 8'h00, 1, 1, 8'h3C); chk("R1", 8'h80);
    step(1, 0, 0, 8'h00, 1, 1, 8'h3C); chk("R1", 8'h80);
    @(negedge clk); rst_n = 1;
    step(1, 1, 1, 8'h00, 1, 1, 8'h3C); chk("R1", 8'h80); // sync not yet out
    step(0, 0, 0, 8'h00, 1, 1, 8'h3C);
    step(0, 0, 0, 8'h00, 1, 1, 8'h3C); chk("R2", 8'h3C);
    step(0, 0, 0, 8'h00, 1, 1, 8'hA5); chk("R2", 8'hA5);
    // program start with 0x5A
    step(0, 1, 0, 8'h5A, 1, 1, 8'h11); chk("R2", 8'h11);
    step(1, 0, 0, 8'hFF, 1, 1, 8'h11); chk("R3", 8'h80); chk("R7", 8'h80);
    // read held for two cycles
    step(1, 0, 0, 8'hFF, 0, 0, 8'h11); chk("R6", 8'h80);
    step(1, 0, 0, 8'hFF, 0, 0, 8'h11); chk("R6", 8'h80);
    step(1, 0, 0, 8'hFF, 1, 0, 8'h11); chk("R5", 8'h80);
    step(1, 0, 0, 8'hFF, 1, 0, 8'h11); chk("R5", 8'hC0); chk("R9", 8'hC0);
    // read ended by chip enable
    step(1, 0, 0, 8'hFF, 0, 0, 8'h11);
    step(1, 0, 0, 8'hFF, 0, 1, 8'h11);
    step(1, 0, 0, 8'hFF, 1, 1, 8'h11); chk("R5", 8'h80);
    step(1, 0, 0, 8'hFF, 0, 0, 8'h11);
    step(1, 0, 0, 8'hFF, 1, 1, 8'h11);
    step(1, 0, 0, 8'hFF, 1, 1, 8'h11); chk("R5", 8'hC0);
    // start while busy must be ignored
    step(1, 1, 1, 8'h00, 1, 1, 8'h11);
    step(1, 0, 0, 8'h00, 1, 1, 8'h11); chk("R8", 8'hC0);
    // completion returns array data immediately
    step(0, 0, 0, 8'h00, 1, 1, 8'h5A); chk("R10", 8'h5A);
    step(0, 0, 0, 8'h00, 0, 0, 8'h77);
    step(0, 0, 0, 8'h00, 1, 1, 8'h77); chk("R2", 8'h77);
    step(1, 0, 0, 8'h00, 1, 1, 8'h77); chk("R6", 8'hC0);
    step(0, 0, 0, 8'h00, 1, 1, 8'hFF);
    // erase start
    step(0, 1, 1, 8'hFF, 1, 1, 8'hFF); chk("R2", 8'hFF);
    step(1, 0, 0, 8'h00, 1, 1, 8'hFF); chk("R4", 8'h00); chk("R7", 8'h00);
    step(1, 0, 0, 8'h00, 0, 0, 8'hFF);
    step(1, 0, 0, 8'h00, 1, 1, 8'hFF);
    step(1, 0, 0, 8'h00, 1, 1, 8'hFF); chk("R4", 8'h40);
    step(0, 0, 0, 8'h00, 1, 1, 8'hFF); chk("R10", 8'hFF);
    // program start with bit 7 set, toggle was 1
    step(0, 1, 0, 8'h80, 1, 1, 8'h00);
    step(1, 0, 1, 8'h00, 1, 1, 8'h00); chk("R3", 8'h00); chk("R7", 8'h00);
    step(1, 0, 0, 8'h00, 0, 0, 8'h00);
    step(1, 0, 0, 8'h00, 1, 1, 8'h00);
    step(1, 0, 0, 8'h00, 1, 1, 8'h00); chk("R9", 8'h40);
    step(0, 0, 0, 8'h00, 1, 1, 8'h96); chk("R10", 8'h96);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule